// File: doc/BRIEF.md
# Serial Register Access Port

This block sits behind a scan-access instruction and gives an external debugger a path into a parallel register bus. Each scan loads a 40-bit frame into the chain, shifts it through one bit per enabled clock and, on the update strobe, turns the frame into a single bus operation. A frame is either a write, which delivers a 32-bit value to a 7-bit register address, or a read request, which names the register whose value will come back in the following scan.

Reads are pipelined by one scan. The read strobe is issued once per read request, at its update, and the returned word is held until the next capture loads it into the chain. Some registers, such as a trace RAM data port, advance an internal pointer on every read. A debugger draining such a port therefore repeats its address for every scan but the last, and names a harmless address in the closing scan. That closing scan brings out the final word without a further pointer step.

Top module: `scan_reg_port`

## Requirements
- R1: The frame is 40 bits and is shifted least significant bit first: bits 31:0 carry data, bits 38:32 carry the register address, and bit 39 is the direction. `tdo` shows frame bit 0, and each shift cycle moves `tdi` into bit 39.
- R2: An update with direction 1 causes a one-cycle `reg_we` pulse in the following cycle. During that pulse `reg_addr` holds the frame's address and `reg_wdata` holds the frame's data field.
- R3: An update with direction 0 latches the address. The next capture loads that register's value into bits 31:0 of the chain. Address and direction bits always capture as zero.
- R4: Each read request causes exactly one one-cycle `reg_re` pulse, in the cycle after its update, with the requested address on `reg_addr`. A write causes no read pulse, and `reg_we` and `reg_re` are never high together.
- R5: A write scan leaves the returned read word untouched. The captures following the write still return the value of the last read request.
- R6: After reset the pending address is 0, the captured data is 0, both strobes are low and `tdo` is 0.
- R7: A run of read requests to a side-effecting register (address 4), closed by a read of address 0, gives exactly one side-effect read per address-4 request. It returns the consecutive words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data into frame bit 39 |
| capture_en | input | 1 | Load the parallel value into the chain |
| shift_en | input | 1 | Shift the chain one bit toward `tdo` |
| update_en | input | 1 | Act on the frame held in the chain |
| tdo | output | 1 | Serial data out, frame bit 0 |
| reg_addr | output | 7 | Register bus address |
| reg_wdata | output | 32 | Register bus write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Register bus read data, valid while `reg_re` is high |

## Verification
Read requests sweep every one of the 128 addresses, each against a distinct value, so that a swapped, shifted or truncated address or data field shows up as a wrong word one scan later. Write scans are placed between reads to separate a stale returned word from a freshly read one. A read issued just before a mid-run reset shows whether reset really clears the pending word. A drain of the side-effecting address, counting pointer steps, tells one read per request apart from a double read at capture.

// File: rtl/scan_reg_port.sv
module scan_reg_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tdi,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  output logic              tdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  localparam int DIR_POS = FRAME_W - 1;

  logic [FRAME_W-1:0] chain;
  logic [DATA_W-1:0]  ret_word;

  wire              fr_write = chain[DIR_POS];
  wire [ADDR_W-1:0] fr_addr  = chain[DATA_W +: ADDR_W];
  wire [DATA_W-1:0] cap_word = reg_re ? reg_rdata : ret_word;

  assign tdo = chain[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (capture_en) begin
      chain <= {{(ADDR_W + 1){1'b0}}, cap_word};
    end else if (shift_en) begin
      chain <= {tdi, chain[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      ret_word  <= '0;
    end else begin
      reg_we <= update_en && fr_write;
      reg_re <= update_en && !fr_write;
      if (update_en) reg_addr <= fr_addr;
      if (update_en && fr_write) reg_wdata <= chain[DATA_W-1:0];
      if (reg_re) ret_word <= reg_rdata;
    end
  end

  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_we_from_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(update_en));
  p_re_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  p_re_from_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> $past(update_en));
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(update_en) |-> $stable(reg_addr));
endmodule

// File: tb/scan_reg_port_test.sv
module scan_reg_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tdi = 1'b0;
  logic        capture_en = 1'b0;
  logic        shift_en = 1'b0;
  logic        update_en = 1'b0;
  logic        tdo;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic        reg_re;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scan_reg_port uut (
    .clk(clk), .rst_n(rst_n), .tdi(tdi), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .tdo(tdo),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // register file model: address 4 is a RAM port whose pointer steps per read
  logic [31:0] rf [0:7];
  int rp = 0;
  int re_cnt = 0;
  int we_cnt = 0;
  logic [6:0]  last_wa = '0;
  logic [31:0] last_wd = '0;

  function automatic logic [31:0] ram_word(input int i);
    return 32'h5A000000 + i * 32'h00010203;
  endfunction

  function automatic logic [31:0] wval(input int a);
    return 32'h11111111 * (a + 1) ^ 32'h00F0F000;
  endfunction

  function automatic logic [31:0] far_val(input int a);
    return 32'hC0DE0000 | a;
  endfunction

  always_comb begin
    if (reg_addr == 7'd4) reg_rdata = ram_word(rp);
    else if (reg_addr < 7'd8) reg_rdata = rf[reg_addr[2:0]];
    else reg_rdata = far_val(int'(reg_addr));
  end

  always_ff @(posedge clk) begin
    if (reg_we) begin
      we_cnt  <= we_cnt + 1;
      last_wa <= reg_addr;
      last_wd <= reg_wdata;
      if (reg_addr < 7'd8 && reg_addr != 7'd4) rf[reg_addr[2:0]] <= reg_wdata;
    end
    if (reg_re) begin
      re_cnt <= re_cnt + 1;
      if (reg_addr == 7'd4) rp <= rp + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic dir, input logic [6:0] a, input logic [31:0] d,
                      output logic [39:0] so);
    logic [39:0] fr;
    fr = {dir, a, d};
    @(negedge clk) capture_en = 1'b1;
    @(negedge clk) begin capture_en = 1'b0; shift_en = 1'b1; end
    for (int i = 0; i < 40; i++) begin
      tdi = fr[i];
      so[i] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0;
    update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [39:0] so;
    int prev;
    int re0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 tdo", {31'b0, tdo}, 32'h0);
    check("R6 strobes", {30'b0, reg_we, reg_re}, 32'h0);
    check("R6 addr", {25'b0, reg_addr}, 32'h0);

    // writes to every plain register; outputs stay at the reset word
    for (int a = 0; a < 8; a++) begin
      if (a == 4) continue;
      scan(1'b1, 7'(a), wval(a), so);
      check(a == 0 ? "R6 first capture" : "R5 write scan out", so[31:0], 32'h0);
      check("R3 hdr zero", {24'b0, so[39:32]}, 32'h0);
      check("R2 write addr", {25'b0, last_wa}, 32'(a));
      check("R2 write data", last_wd, wval(a));
    end
    check("R2 write count", 32'(we_cnt), 32'd7);
    check("R4 no read on write", 32'(re_cnt), 32'd0);

    // exhaustive pipelined read sweep
    re0 = re_cnt;
    prev = -1;
    for (int a = 0; a < 128; a++) begin
      if (a == 4) continue;
      scan(1'b0, 7'(a), 32'hFFFFFFFF, so);
      if (prev >= 0) begin
        check("R3 read word", so[31:0], prev < 8 ? wval(prev) : far_val(prev));
        check("R3 hdr zero", {24'b0, so[39:32]}, 32'h0);
      end
      prev = a;
    end
    scan(1'b0, 7'd0, 32'h0, so);
    check("R3 last read word", so[31:0], far_val(127));
    check("R4 read count", 32'(re_cnt - re0), 32'd128);
    check("R1 bus addr", {25'b0, reg_addr}, 32'h0);

    // R5: write between read request and its return
    scan(1'b0, 7'd2, 32'h0, so);
    scan(1'b1, 7'd3, 32'hDEADBEEF, so);
    check("R5 write scan returns read", so[31:0], wval(2));
    scan(1'b0, 7'd3, 32'h0, so);
    check("R5 still pending word", so[31:0], wval(2));
    scan(1'b0, 7'd0, 32'h0, so);
    check("R2 written value read back", so[31:0], 32'hDEADBEEF);

    // R7: drain side-effect register
    check("R7 pointer start", 32'(rp), 32'd0);
    for (int k = 0; k < 5; k++) begin
      scan(1'b0, 7'd4, 32'h0, so);
      if (k > 0) check("R7 ram word", so[31:0], ram_word(k - 1));
    end
    scan(1'b0, 7'd0, 32'h0, so);
    check("R7 last ram word", so[31:0], ram_word(4));
    check("R7 pointer steps", 32'(rp), 32'd5);
    scan(1'b0, 7'd0, 32'h0, so);
    check("R7 closing read harmless", 32'(rp), 32'd5);
    check("R7 closing word", so[31:0], wval(0));

    // R6: reset discards pending read
    scan(1'b0, 7'd5, 32'h0, so);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    check("R6 addr after reset", {25'b0, reg_addr}, 32'h0);
    scan(1'b0, 7'd1, 32'h0, so);
    check("R6 word after reset", so[31:0], 32'h0);
    scan(1'b0, 7'd0, 32'h0, so);
    check("R3 read after reset", so[31:0], wval(1));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule